// File: doc/BRIEF.md
# Masked Stream-ID Match and Routing Table

This block is the front end that steers I/O transactions in an I/O memory management unit. It holds a fixed set of match slots. Each slot has a stream ID, a don't-care mask and a valid flag. Next to each slot sits a routing word that names a context bank and chooses between translating through that bank and passing the address through unchanged. For every incoming stream ID, all valid slots are compared in parallel. A single hit picks the routing word with the same index. Two or more hits give a conflict fault, and no context is chosen. No hit falls back to a global policy bit.

Software fills both tables through a plain write port, one slot, one routing word or the policy bit per cycle. A typical use is to point a live stream at a bypass routing word during bring-up. Later, only that routing word is rewritten to move the stream into a translating bank, and the match slot is left alone. Lookups enter through a valid/ready request port. Each result comes back from a single output register with its own valid/ready handshake.

Top module: `stream_match_table`

## Requirements
- R1: After reset no slot is valid, every routing word selects bypass with context 0, and the unmatched policy selects fault. `rsp_valid_o` is 0 and `req_ready_o` is 1.
- R2: A slot hits when `(sid ^ slot_id) & ~slot_mask` is zero. A mask bit of 1 excludes that bit from the comparison.
- R3: A slot whose valid flag is 0 never hits, whatever its ID and mask hold.
- R4: With exactly one hit at index k, the response has `rsp_idx_o`=k and `rsp_cb_o` equal to the context of routing word k. `rsp_action_o` is 1 (translate) when routing word k has its translate bit set, and 0 (bypass) otherwise.
- R5: With no hit, `rsp_unmatched_o` is 1, `rsp_cb_o` and `rsp_idx_o` are 0, and `rsp_action_o` is 0 (bypass) if the policy bit is 1, or 2 (fault) if it is 0.
- R6: With two or more hits, `rsp_conflict_o` is 1, `rsp_action_o` is 2 (fault), `rsp_cb_o` and `rsp_idx_o` are 0, and `rsp_unmatched_o` is 0.
- R7: Rewriting a routing word changes the result for streams that hit its slot, and the match slot stays untouched. Write kinds are: 0 writes a match slot (`wr_id_i`, `wr_mask_i`, `wr_vld_i`), 1 writes a routing word (`wr_trans_i`, `wr_cb_i`), 2 writes the policy bit (`wr_unm_bypass_i`), and 3 has no effect.
- R8: A request accepted on a clock edge (`req_valid_i` and `req_ready_o` both high) gives `rsp_valid_o` from that edge, with `rsp_sid_o` echoing the ID. The response holds steady while `rsp_ready_i` is low, and `req_ready_o` is low while a response is waiting.
- R9: A write on the same edge as an accepted lookup does not affect that lookup. It applies to lookups accepted on later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_kind_i | input | 2 | Write target: 0 slot, 1 routing word, 2 policy, 3 none |
| wr_idx_i | input | IDX_W (4) | Slot or routing word index |
| wr_id_i | input | SID_W (16) | Slot stream ID |
| wr_mask_i | input | SID_W (16) | Slot don't-care mask |
| wr_vld_i | input | 1 | Slot valid flag |
| wr_trans_i | input | 1 | Routing word: 1 translate, 0 bypass |
| wr_cb_i | input | CB_W (6) | Routing word context bank |
| wr_unm_bypass_i | input | 1 | Unmatched policy: 1 bypass, 0 fault |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Lookup request accepted |
| req_sid_i | input | SID_W (16) | Stream ID to look up |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Result consumed |
| rsp_sid_o | output | SID_W (16) | Echoed stream ID |
| rsp_action_o | output | 2 | 0 bypass, 1 translate, 2 fault |
| rsp_cb_o | output | CB_W (6) | Context bank |
| rsp_idx_o | output | IDX_W (4) | Index of the hit slot |
| rsp_unmatched_o | output | 1 | No slot hit |
| rsp_conflict_o | output | 1 | Two or more slots hit |

## Verification
The assertions assume that every input carries a known value on each rising edge, and that the request ID counts only in a cycle where the handshake completes. They do not assume that the producer holds its request while `req_ready_o` is low. The bench drives all inputs on falling edges and withdraws `req_valid_i` after each accepted lookup. It lowers `rsp_ready_i` only in a dedicated back-pressure phase, so every sampled response can be tied to one known request. Random slot IDs are drawn from a narrow range with small masks, so that single hits, misses and overlapping slots all occur often.

// File: rtl/smt_pkg.sv
package smt_pkg;
  typedef enum logic [1:0] {
    ACT_BYPASS = 2'd0,
    ACT_TRANS  = 2'd1,
    ACT_FAULT  = 2'd2
  } smt_action_e;

  typedef enum logic [1:0] {
    WK_MATCH  = 2'd0,
    WK_ROUTE  = 2'd1,
    WK_POLICY = 2'd2,
    WK_NONE   = 2'd3
  } smt_wr_kind_e;
endpackage

// File: rtl/smt_tables.sv
module smt_tables
  import smt_pkg::*;
#(
  parameter int unsigned N_ENT = 16,
  parameter int unsigned SID_W = 16,
  parameter int unsigned CB_W  = 6,
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_kind_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [SID_W-1:0] wr_id_i,
  input  logic [SID_W-1:0] wr_mask_i,
  input  logic             wr_vld_i,
  input  logic             wr_trans_i,
  input  logic [CB_W-1:0]  wr_cb_i,
  input  logic             wr_unm_bypass_i,
  output logic [SID_W-1:0] ent_id_o   [N_ENT],
  output logic [SID_W-1:0] ent_mask_o [N_ENT],
  output logic             ent_vld_o  [N_ENT],
  output logic             rt_trans_o [N_ENT],
  output logic [CB_W-1:0]  rt_cb_o    [N_ENT],
  output logic             unm_bypass_o
);

  logic wr_match, wr_route, wr_policy;

  assign wr_match  = wr_en_i && (wr_kind_i == WK_MATCH);
  assign wr_route  = wr_en_i && (wr_kind_i == WK_ROUTE);
  assign wr_policy = wr_en_i && (wr_kind_i == WK_POLICY);

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic sel;
    assign sel = (wr_idx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_id_o[e]   <= '0;
        ent_mask_o[e] <= '0;
        ent_vld_o[e]  <= 1'b0;
      end else if (wr_match && sel) begin
        ent_id_o[e]   <= wr_id_i;
        ent_mask_o[e] <= wr_mask_i;
        ent_vld_o[e]  <= wr_vld_i;
      end
    end

    // reset routing: bypass, context 0
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rt_trans_o[e] <= 1'b0;
        rt_cb_o[e]    <= '0;
      end else if (wr_route && sel) begin
        rt_trans_o[e] <= wr_trans_i;
        rt_cb_o[e]    <= wr_cb_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        unm_bypass_o <= 1'b0;
    else if (wr_policy) unm_bypass_o <= wr_unm_bypass_i;
  end

endmodule

// File: rtl/smt_match.sv
module smt_match #(
  parameter int unsigned N_ENT = 16,
  parameter int unsigned SID_W = 16
) (
  input  logic [SID_W-1:0] sid_i,
  input  logic [SID_W-1:0] ent_id_i   [N_ENT],
  input  logic [SID_W-1:0] ent_mask_i [N_ENT],
  input  logic             ent_vld_i  [N_ENT],
  output logic [N_ENT-1:0] hit_o
);

  for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
    logic [SID_W-1:0] diff;
    assign diff     = (sid_i ^ ent_id_i[e]) & ~ent_mask_i[e];
    assign hit_o[e] = ent_vld_i[e] && (diff == '0);
  end

endmodule

// File: rtl/smt_resolve.sv
module smt_resolve
  import smt_pkg::*;
#(
  parameter int unsigned N_ENT = 16,
  parameter int unsigned CB_W  = 6,
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [N_ENT-1:0] hit_i,
  input  logic             rt_trans_i [N_ENT],
  input  logic [CB_W-1:0]  rt_cb_i    [N_ENT],
  input  logic             unm_bypass_i,
  output logic [1:0]       action_o,
  output logic [CB_W-1:0]  cb_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             unmatched_o,
  output logic             conflict_o
);

  logic             any_hit;
  logic             multi_hit;
  logic [IDX_W-1:0] or_idx;
  logic             sel_trans;
  logic [CB_W-1:0]  sel_cb;

  // OR-encoding is exact when at most one bit is set
  always_comb begin
    any_hit   = 1'b0;
    multi_hit = 1'b0;
    or_idx    = '0;
    sel_trans = 1'b0;
    sel_cb    = '0;
    for (int e = 0; e < N_ENT; e++) begin
      if (hit_i[e]) begin
        multi_hit = multi_hit | any_hit;
        any_hit   = 1'b1;
        or_idx    = or_idx | IDX_W'(e);
        sel_trans = sel_trans | rt_trans_i[e];
        sel_cb    = sel_cb | rt_cb_i[e];
      end
    end
  end

  always_comb begin
    action_o    = ACT_FAULT;
    cb_o        = '0;
    idx_o       = '0;
    unmatched_o = 1'b0;
    conflict_o  = 1'b0;
    if (multi_hit) begin
      conflict_o = 1'b1;
    end else if (!any_hit) begin
      unmatched_o = 1'b1;
      action_o    = unm_bypass_i ? ACT_BYPASS : ACT_FAULT;
    end else begin
      action_o = sel_trans ? ACT_TRANS : ACT_BYPASS;
      cb_o     = sel_cb;
      idx_o    = or_idx;
    end
  end

endmodule

// File: rtl/smt_out_reg.sv
module smt_out_reg #(
  parameter int unsigned PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [PW-1:0] in_data_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [PW-1:0] out_data_o
);

  assign in_ready_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_data_o <= in_data_i;
    end
  end

endmodule

// File: rtl/stream_match_table.sv
module stream_match_table
  import smt_pkg::*;
#(
  parameter int unsigned N_ENT = 16,
  parameter int unsigned SID_W = 16,
  parameter int unsigned CB_W  = 6,
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int unsigned PW    = SID_W + 2 + CB_W + IDX_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_kind_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [SID_W-1:0] wr_id_i,
  input  logic [SID_W-1:0] wr_mask_i,
  input  logic             wr_vld_i,
  input  logic             wr_trans_i,
  input  logic [CB_W-1:0]  wr_cb_i,
  input  logic             wr_unm_bypass_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [SID_W-1:0] req_sid_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [SID_W-1:0] rsp_sid_o,
  output logic [1:0]       rsp_action_o,
  output logic [CB_W-1:0]  rsp_cb_o,
  output logic [IDX_W-1:0] rsp_idx_o,
  output logic             rsp_unmatched_o,
  output logic             rsp_conflict_o
);

  logic [SID_W-1:0] ent_id   [N_ENT];
  logic [SID_W-1:0] ent_mask [N_ENT];
  logic             ent_vld  [N_ENT];
  logic             rt_trans [N_ENT];
  logic [CB_W-1:0]  rt_cb    [N_ENT];
  logic             unm_bypass;
  logic [N_ENT-1:0] hit;

  logic [1:0]       lk_action;
  logic [CB_W-1:0]  lk_cb;
  logic [IDX_W-1:0] lk_idx;
  logic             lk_unm;
  logic             lk_conf;
  logic [PW-1:0]    lk_data;
  logic [PW-1:0]    rsp_data;

  smt_tables #(.N_ENT(N_ENT), .SID_W(SID_W), .CB_W(CB_W)) i_tables (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wr_en_i         (wr_en_i),
    .wr_kind_i       (wr_kind_i),
    .wr_idx_i        (wr_idx_i),
    .wr_id_i         (wr_id_i),
    .wr_mask_i       (wr_mask_i),
    .wr_vld_i        (wr_vld_i),
    .wr_trans_i      (wr_trans_i),
    .wr_cb_i         (wr_cb_i),
    .wr_unm_bypass_i (wr_unm_bypass_i),
    .ent_id_o        (ent_id),
    .ent_mask_o      (ent_mask),
    .ent_vld_o       (ent_vld),
    .rt_trans_o      (rt_trans),
    .rt_cb_o         (rt_cb),
    .unm_bypass_o    (unm_bypass)
  );

  smt_match #(.N_ENT(N_ENT), .SID_W(SID_W)) i_match (
    .sid_i      (req_sid_i),
    .ent_id_i   (ent_id),
    .ent_mask_i (ent_mask),
    .ent_vld_i  (ent_vld),
    .hit_o      (hit)
  );

  smt_resolve #(.N_ENT(N_ENT), .CB_W(CB_W)) i_resolve (
    .hit_i        (hit),
    .rt_trans_i   (rt_trans),
    .rt_cb_i      (rt_cb),
    .unm_bypass_i (unm_bypass),
    .action_o     (lk_action),
    .cb_o         (lk_cb),
    .idx_o        (lk_idx),
    .unmatched_o  (lk_unm),
    .conflict_o   (lk_conf)
  );

  // tables are read before this edge's write lands
  assign lk_data = {req_sid_i, lk_action, lk_cb, lk_idx, lk_unm, lk_conf};

  smt_out_reg #(.PW(PW)) i_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (req_valid_i),
    .in_ready_o  (req_ready_o),
    .in_data_i   (lk_data),
    .out_valid_o (rsp_valid_o),
    .out_ready_i (rsp_ready_i),
    .out_data_o  (rsp_data)
  );

  assign {rsp_sid_o, rsp_action_o, rsp_cb_o, rsp_idx_o,
          rsp_unmatched_o, rsp_conflict_o} = rsp_data;

endmodule

// File: rtl/smt_checker.sv
module smt_checker
  import smt_pkg::*;
#(
  parameter int unsigned SID_W = 16,
  parameter int unsigned CB_W  = 6,
  parameter int unsigned IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [SID_W-1:0] req_sid_i,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic [SID_W-1:0] rsp_sid_o,
  input logic [1:0]       rsp_action_o,
  input logic [CB_W-1:0]  rsp_cb_o,
  input logic [IDX_W-1:0] rsp_idx_o,
  input logic             rsp_unmatched_o,
  input logic             rsp_conflict_o
);

  a_r6_conflict_faults : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_conflict_o |->
      rsp_action_o == ACT_FAULT && !rsp_unmatched_o && rsp_cb_o == '0 && rsp_idx_o == '0);

  a_r5_unmatched_no_trans : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_unmatched_o |->
      rsp_action_o != ACT_TRANS && rsp_cb_o == '0 && rsp_idx_o == '0);

  a_r4_action_legal : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_action_o != 2'd3);

  a_r8_accept_echo : assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_valid_o && rsp_sid_o == $past(req_sid_i));

  a_r8_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=>
      rsp_valid_o && $stable(rsp_sid_o) && $stable(rsp_action_o) &&
      $stable(rsp_cb_o) && $stable(rsp_idx_o) && $stable(rsp_conflict_o));

  a_r8_blocked : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |-> !req_ready_o);

  a_r8_no_spurious : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) && (rsp_ready_i || !rsp_valid_o) |=> !rsp_valid_o);

endmodule

bind stream_match_table smt_checker #(.SID_W(SID_W), .CB_W(CB_W), .IDX_W(IDX_W)) i_smt_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .req_sid_i       (req_sid_i),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_ready_i     (rsp_ready_i),
  .rsp_sid_o       (rsp_sid_o),
  .rsp_action_o    (rsp_action_o),
  .rsp_cb_o        (rsp_cb_o),
  .rsp_idx_o       (rsp_idx_o),
  .rsp_unmatched_o (rsp_unmatched_o),
  .rsp_conflict_o  (rsp_conflict_o)
);

// File: tb/test_stream_match_table.sv
`timescale 1ns/1ps
module test_stream_match_table;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kind = '0;
  logic [3:0]  wr_idx = '0;
  logic [15:0] wr_id = '0;
  logic [15:0] wr_mask = '0;
  logic        wr_vld = 1'b0;
  logic        wr_trans = 1'b0;
  logic [5:0]  wr_cb = '0;
  logic        wr_unm = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_sid = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_sid;
  logic [1:0]  rsp_action;
  logic [5:0]  rsp_cb;
  logic [3:0]  rsp_idx;
  logic        rsp_unm;
  logic        rsp_conf;

  int n_checks = 0;
  int n_fail = 0;

  // bench model of the tables
  logic [15:0] m_id   [N];
  logic [15:0] m_mask [N];
  logic        m_vld  [N];
  logic        m_trans[N];
  logic [5:0]  m_cb   [N];
  logic        m_unm;

  always #10 clk = ~clk;

  stream_match_table i_stream_match_table (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_kind_i(wr_kind), .wr_idx_i(wr_idx), .wr_id_i(wr_id),
    .wr_mask_i(wr_mask), .wr_vld_i(wr_vld), .wr_trans_i(wr_trans), .wr_cb_i(wr_cb),
    .wr_unm_bypass_i(wr_unm),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_sid_i(req_sid),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_sid_o(rsp_sid),
    .rsp_action_o(rsp_action), .rsp_cb_o(rsp_cb), .rsp_idx_o(rsp_idx),
    .rsp_unmatched_o(rsp_unm), .rsp_conflict_o(rsp_conf)
  );

  function automatic logic [13:0] expect_of(input logic [15:0] sid);
    int hits = 0;
    int h = 0;
    logic [1:0] act;
    logic [5:0] cb;
    logic [3:0] idx;
    logic unm, conf;
    for (int e = 0; e < N; e++)
      if (m_vld[e] && (((sid ^ m_id[e]) & ~m_mask[e]) == 16'h0)) begin
        hits++;
        h = e;
      end
    act = 2'd2; cb = '0; idx = '0; unm = 1'b0; conf = 1'b0;
    if (hits > 1) conf = 1'b1;
    else if (hits == 0) begin
      unm = 1'b1;
      act = m_unm ? 2'd0 : 2'd2;
    end else begin
      act = m_trans[h] ? 2'd1 : 2'd0;
      cb  = m_cb[h];
      idx = 4'(h);
    end
    return {act, cb, idx, unm, conf};
  endfunction

  function automatic logic [13:0] actual_rsp();
    return {rsp_action, rsp_cb, rsp_idx, rsp_unm, rsp_conf};
  endfunction

  task automatic check_rsp(input string tag, input logic [15:0] sid, input logic [13:0] exp);
    n_checks++;
    if (!rsp_valid || rsp_sid !== sid || actual_rsp() !== exp) begin
      n_fail++;
      $display("FAIL %s: actual vld=%0b sid=%h res=%h expected vld=1 sid=%h res=%h",
               tag, rsp_valid, rsp_sid, actual_rsp(), sid, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic drive_wr(input logic [1:0] kind, input int idx, input logic [15:0] id,
                          input logic [15:0] mask, input logic vld, input logic trans,
                          input logic [5:0] cb, input logic unm);
    wr_en = 1'b1; wr_kind = kind; wr_idx = 4'(idx); wr_id = id; wr_mask = mask;
    wr_vld = vld; wr_trans = trans; wr_cb = cb; wr_unm = unm;
  endtask

  task automatic model_wr();
    if (wr_kind == 2'd0) begin
      m_id[wr_idx] = wr_id; m_mask[wr_idx] = wr_mask; m_vld[wr_idx] = wr_vld;
    end else if (wr_kind == 2'd1) begin
      m_trans[wr_idx] = wr_trans; m_cb[wr_idx] = wr_cb;
    end else if (wr_kind == 2'd2) begin
      m_unm = wr_unm;
    end
  endtask

  task automatic do_wr(input logic [1:0] kind, input int idx, input logic [15:0] id,
                       input logic [15:0] mask, input logic vld, input logic trans,
                       input logic [5:0] cb, input logic unm);
    @(negedge clk);
    drive_wr(kind, idx, id, mask, vld, trans, cb, unm);
    @(negedge clk);
    wr_en = 1'b0;
    model_wr();
  endtask

  task automatic do_lookup(input string tag, input logic [15:0] sid);
    logic [13:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_sid = sid; rsp_ready = 1'b1;
    exp = expect_of(sid);
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(tag, sid, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [13:0] exp;
    logic [13:0] held;
    void'($urandom(32'd2025));
    for (int e = 0; e < N; e++) begin
      m_id[e] = '0; m_mask[e] = '0; m_vld[e] = 1'b0; m_trans[e] = 1'b0; m_cb[e] = '0;
    end
    m_unm = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_bit("R1 rsp_valid after reset", rsp_valid, 1'b0);
    check_bit("R1 req_ready after reset", req_ready, 1'b1);
    do_lookup("R1 empty table faults unmatched", 16'h1234);

    // R2 mask: slot 3 = 0x1c00 / 0x0002
    do_wr(2'd0, 3, 16'h1c00, 16'h0002, 1'b1, 1'b0, 6'd0, 1'b0);
    do_lookup("R2 masked bit differs, R1 reset route bypass cb0", 16'h1c02);
    do_lookup("R2 unmasked bit differs misses", 16'h1c01);

    // R4/R7 route rewrite only
    do_wr(2'd1, 3, 16'h0, 16'h0, 1'b0, 1'b1, 6'd9, 1'b0);
    do_lookup("R4 R7 single hit translates via cb 9", 16'h1c00);

    // R7 kind 3 no effect
    do_wr(2'd3, 3, 16'hffff, 16'hffff, 1'b0, 1'b0, 6'd63, 1'b1);
    do_lookup("R7 kind 3 write ignored", 16'h1c00);

    // R5 policy bypass
    do_wr(2'd2, 0, 16'h0, 16'h0, 1'b0, 1'b0, 6'd0, 1'b1);
    do_lookup("R5 unmatched bypass policy", 16'h5555);

    // R6 overlap
    do_wr(2'd0, 7, 16'h1c00, 16'h0000, 1'b1, 1'b1, 6'd0, 1'b0);
    do_wr(2'd1, 7, 16'h0, 16'h0, 1'b0, 1'b1, 6'd33, 1'b0);
    do_lookup("R6 two hits conflict", 16'h1c00);
    do_lookup("R6 only one slot covers sid", 16'h1c02);

    // R3 invalid slot ignored
    do_wr(2'd0, 7, 16'h1c00, 16'h0000, 1'b0, 1'b0, 6'd0, 1'b0);
    do_lookup("R3 cleared valid no longer hits", 16'h1c00);

    // R9 write and lookup on same edge
    @(negedge clk);
    drive_wr(2'd1, 3, 16'h0, 16'h0, 1'b0, 1'b1, 6'd20, 1'b0);
    req_valid = 1'b1; req_sid = 16'h1c00;
    exp = expect_of(16'h1c00);
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    model_wr();
    check_rsp("R9 same-edge write not seen", 16'h1c00, exp);
    do_lookup("R9 write seen by next lookup", 16'h1c00);

    // R8 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_sid = 16'h1c02;
    held = expect_of(16'h1c02);
    @(negedge clk);
    req_valid = 1'b1; req_sid = 16'h7777;
    check_rsp("R8 response registered", 16'h1c02, held);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_rsp("R8 response held under back-pressure", 16'h1c02, held);
      check_bit("R8 req_ready low while stalled", req_ready, 1'b0);
    end
    req_valid = 1'b0; rsp_ready = 1'b1;
    @(negedge clk);
    check_bit("R8 response drained", rsp_valid, 1'b0);

    // random mix
    for (int it = 0; it < 600; it++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 3) begin
        int e;
        e = int'($urandom % N);
        do_wr(2'd0, e, {12'h1c0, 4'($urandom)}, 16'($urandom) & 16'h000b,
              ($urandom % 4) != 0, 1'b0, 6'd0, 1'b0);
      end else if (r < 5) begin
        do_wr(2'd1, int'($urandom % N), 16'h0, 16'h0, 1'b0, 1'($urandom), 6'($urandom), 1'b0);
      end else if (r < 6) begin
        do_wr(2'd2, 0, 16'h0, 16'h0, 1'b0, 1'b0, 6'd0, 1'($urandom));
      end else begin
        logic [15:0] sid;
        int e;
        e = int'($urandom % N);
        sid = ($urandom % 4 == 0) ? 16'($urandom) : (m_id[e] ^ (16'($urandom) & m_mask[e]));
        do_lookup("R2 R3 R4 R5 R6 random lookup", sid);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule